// File: doc/BRIEF.md
# Module Clock Enable Sequencer

This block switches one peripheral module's functional clock on or off by editing a clock-control word over a simple single-cycle register bus and then watching the module's idle-status field until the module reports the state that was asked for. A command port accepts one enable or disable request at a time. The block raises `cmd_busy` while it works and ends each command with a single-cycle `cmd_done` pulse. `cmd_err` is valid on that pulse.

Around the register accesses, a clock-domain request is sequenced. An enable asks for the domain first and only touches the register once the domain grants the request. A disable edits the register and waits, then releases the domain as its very last step. The waits are timed in microseconds from a free-running tick. An enable that times out is an error. A disable that times out simply stops waiting. A standby flag taken from the most recently read control word is brought out as a status output.

Top module: `modclk_seq`

## Requirements
- R1: An enable raises `dom_req` and waits for `dom_ack`. It then reads the control word and writes it back with bits [1:0] replaced by the mode code captured at acceptance (1 hardware-supervised, 2 software-supervised). All other bits are unchanged, and each write directly follows a read.
- R2: A disable reads the control word and writes it back with bits [1:0] cleared to 0. All other bits are unchanged.
- R3: If `dom_fail` is seen while an enable waits for the domain, the command ends with `cmd_err`=1 and no register access, and `dom_req` drops.
- R4: After an enable write, the block polls the control word until bits [17:16] read 0 (functional) or 2 (interface idle), then finishes with `cmd_err`=0.
- R5: If an enable poll has not seen a ready code after 2000 `us_tick` pulses counted from the start of polling, the command ends with `cmd_err`=1.
- R6: After a disable write, the block polls until bits [17:16] read 3 (disabled). After 5000 ticks it stops waiting, and the command still ends with `cmd_err`=0.
- R7: A disable drops `dom_req` in the cycle just before `cmd_done`, including after a poll timeout. An enable that completes leaves `dom_req` high.
- R8: With `cfg_skip_poll`=1, a command performs exactly one read and one write and no polling.
- R9: With mode code 0, an enable performs only the domain request and a disable performs only the domain release. Neither accesses the register.
- R10: `standby` equals bit 18 of the most recently read control word, and is 0 after reset.
- R11: Only one command runs at a time. `cmd_busy` stays high from acceptance through the one-cycle `cmd_done` pulse, and `cmd_valid` has no effect while busy.
- R12: After reset, `cmd_busy`, `cmd_done`, `cmd_err`, `dom_req`, `bus_rd`, `bus_wr` and `standby` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_enable | input | 1 | 1 = enable the module clock, 0 = disable it |
| cmd_busy | output | 1 | A command is in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Failure flag, valid with `cmd_done` |
| cfg_mode | input | 2 | Mode code written on enable (0, 1 or 2) |
| cfg_skip_poll | input | 1 | Skip idle-status polling after the write |
| dom_req | output | 1 | Clock-domain request, level |
| dom_ack | input | 1 | Domain grant |
| dom_fail | input | 1 | Domain refusal |
| bus_rd | output | 1 | Read strobe; data returns the following cycle |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data from the control word |
| us_tick | input | 1 | One pulse per microsecond |
| standby | output | 1 | Standby flag from the last read |

## Verification
The assertions assume that `bus_rdata` holds the value read one cycle after each `bus_rd` and stays stable until the next read. They also assume that `dom_ack` and `dom_fail` are level signals that react only to `dom_req`, and that `us_tick` is a single-cycle pulse. The bench's register and domain responders change their outputs only on the falling clock edge, update the read word only in the cycle after a read strobe, and derive the grant or refusal from how long `dom_req` has been held. Commands are issued at the falling edge, and `cmd_valid` is held over several busy cycles to exercise R11.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DOM_WAIT,
        SQ_READ,
        SQ_WRITE,
        SQ_POLL_RD,
        SQ_POLL_CHK,
        SQ_RELEASE,
        SQ_FINISH
    } seq_state_e;

    localparam logic [1:0] MODE_OFF      = 2'd0;
    localparam logic [1:0] MODE_HW       = 2'd1;
    localparam logic [1:0] MODE_SW       = 2'd2;

    localparam logic [1:0] IDLE_FUNC     = 2'd0;
    localparam logic [1:0] IDLE_IF_QUIET = 2'd2;
    localparam logic [1:0] IDLE_GATED    = 2'd3;

    typedef struct packed {
        seq_state_e st;
        logic       dir_on;
        logic [1:0] mode;
        logic       skip;
        logic       dom;
        logic       fail;
        logic       stby;
    } seq_regs_t;

endpackage

// File: rtl/clkseq_field.sv
module clkseq_field #(
    parameter int DATA_W   = 32,
    parameter int MODE_LSB = 0,
    parameter int IDLE_LSB = 16,
    parameter int STBY_BIT = 18
) (
    input  logic [DATA_W-1:0] rd_word,
    input  logic              dir_on,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] wr_word,
    output logic              up_ok,
    output logic              down_ok,
    output logic              stby_bit
);
    import clkseq_pkg::*;

    localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'(3) << MODE_LSB;

    logic [1:0]        idle_code;
    logic [DATA_W-1:0] mode_ins;

    always_comb begin
        mode_ins  = dir_on ? (DATA_W'(mode) << MODE_LSB) : '0;
        wr_word   = (rd_word & ~MODE_MASK) | mode_ins;
        idle_code = rd_word[IDLE_LSB +: 2];
        up_ok     = (idle_code == IDLE_FUNC) || (idle_code == IDLE_IF_QUIET);
        down_ok   = (idle_code == IDLE_GATED);
        stby_bit  = rd_word[STBY_BIT];
    end

endmodule

// File: rtl/clkseq_tmo.sv
module clkseq_tmo #(
    parameter int UP_LIMIT   = 2000,
    parameter int DOWN_LIMIT = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    input  logic dir_on,
    output logic expired
);
    localparam int MAX_LIM = (UP_LIMIT > DOWN_LIMIT) ? UP_LIMIT : DOWN_LIMIT;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);
    localparam logic [CNT_W-1:0] UP_CNT   = CNT_W'(UP_LIMIT);
    localparam logic [CNT_W-1:0] DOWN_CNT = CNT_W'(DOWN_LIMIT);
    localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(MAX_LIM);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && tick && (cnt_q != SAT_CNT)) begin
            cnt_d = cnt_q + 1'b1;
        end
        expired = cnt_q >= (dir_on ? UP_CNT : DOWN_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/clkseq_fsm.sv
module clkseq_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       cmd_enable,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_skip_poll,
    input  logic       dom_ack,
    input  logic       dom_fail,
    input  logic       up_ok,
    input  logic       down_ok,
    input  logic       stby_bit,
    input  logic       expired,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic       dom_req,
    output logic       rd_stb,
    output logic       wr_stb,
    output logic       tmo_clear,
    output logic       tmo_run,
    output logic       dir_on,
    output logic [1:0] mode,
    output logic       stby
);
    import clkseq_pkg::*;

    seq_regs_t r_d, r_q;
    logic      settled;
    seq_state_e after_wait;

    always_comb begin
        r_d        = r_q;
        settled    = r_q.dir_on ? up_ok : down_ok;
        after_wait = r_q.dir_on ? SQ_FINISH : SQ_RELEASE;
        case (r_q.st)
            SQ_IDLE: begin
                if (cmd_valid) begin
                    r_d.dir_on = cmd_enable;
                    r_d.mode   = cfg_mode;
                    r_d.skip   = cfg_skip_poll;
                    r_d.fail   = 1'b0;
                    if (cmd_enable) begin
                        r_d.dom = 1'b1;
                        r_d.st  = SQ_DOM_WAIT;
                    end else begin
                        r_d.st = (cfg_mode == MODE_OFF) ? SQ_RELEASE : SQ_READ;
                    end
                end
            end
            SQ_DOM_WAIT: begin
                if (dom_fail) begin
                    r_d.fail = 1'b1;
                    r_d.dom  = 1'b0;
                    r_d.st   = SQ_FINISH;
                end else if (dom_ack) begin
                    r_d.st = (r_q.mode == MODE_OFF) ? SQ_FINISH : SQ_READ;
                end
            end
            SQ_READ: begin
                r_d.st = SQ_WRITE;
            end
            SQ_WRITE: begin
                r_d.stby = stby_bit;
                r_d.st   = r_q.skip ? after_wait : SQ_POLL_RD;
            end
            SQ_POLL_RD: begin
                r_d.st = SQ_POLL_CHK;
            end
            SQ_POLL_CHK: begin
                r_d.stby = stby_bit;
                if (settled) begin
                    r_d.st = after_wait;
                end else if (expired) begin
                    r_d.fail = r_q.dir_on;
                    r_d.st   = after_wait;
                end else begin
                    r_d.st = SQ_POLL_RD;
                end
            end
            SQ_RELEASE: begin
                r_d.dom = 1'b0;
                r_d.st  = SQ_FINISH;
            end
            SQ_FINISH: begin
                r_d.st = SQ_IDLE;
            end
            default: begin
                r_d.st = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SQ_IDLE, dir_on: 1'b0, mode: MODE_OFF, skip: 1'b0,
                     dom: 1'b0, fail: 1'b0, stby: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy      = (r_q.st != SQ_IDLE);
        done      = (r_q.st == SQ_FINISH);
        err       = done && r_q.fail;
        dom_req   = r_q.dom;
        rd_stb    = (r_q.st == SQ_READ) || (r_q.st == SQ_POLL_RD);
        wr_stb    = (r_q.st == SQ_WRITE);
        tmo_clear = (r_q.st == SQ_WRITE);
        tmo_run   = (r_q.st == SQ_POLL_RD) || (r_q.st == SQ_POLL_CHK);
        dir_on    = r_q.dir_on;
        mode      = r_q.mode;
        stby      = r_q.stby;
    end

endmodule

// File: rtl/modclk_seq.sv
module modclk_seq #(
    parameter int DATA_W       = 32,
    parameter int MODE_LSB     = 0,
    parameter int IDLE_LSB     = 16,
    parameter int STBY_BIT     = 18,
    parameter int EN_LIMIT_US  = 2000,
    parameter int DIS_LIMIT_US = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_enable,
    output logic              cmd_busy,
    output logic              cmd_done,
    output logic              cmd_err,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_skip_poll,
    output logic              dom_req,
    input  logic              dom_ack,
    input  logic              dom_fail,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              us_tick,
    output logic              standby
);
    logic       up_ok, down_ok, stby_bit, expired;
    logic       tmo_clear, tmo_run, dir_on;
    logic [1:0] mode;

    clkseq_field #(
        .DATA_W   (DATA_W),
        .MODE_LSB (MODE_LSB),
        .IDLE_LSB (IDLE_LSB),
        .STBY_BIT (STBY_BIT)
    ) u_field (
        .rd_word  (bus_rdata),
        .dir_on   (dir_on),
        .mode     (mode),
        .wr_word  (bus_wdata),
        .up_ok    (up_ok),
        .down_ok  (down_ok),
        .stby_bit (stby_bit)
    );

    clkseq_tmo #(
        .UP_LIMIT   (EN_LIMIT_US),
        .DOWN_LIMIT (DIS_LIMIT_US)
    ) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmo_clear),
        .run     (tmo_run),
        .tick    (us_tick),
        .dir_on  (dir_on),
        .expired (expired)
    );

    clkseq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_enable    (cmd_enable),
        .cfg_mode      (cfg_mode),
        .cfg_skip_poll (cfg_skip_poll),
        .dom_ack       (dom_ack),
        .dom_fail      (dom_fail),
        .up_ok         (up_ok),
        .down_ok       (down_ok),
        .stby_bit      (stby_bit),
        .expired       (expired),
        .busy          (cmd_busy),
        .done          (cmd_done),
        .err           (cmd_err),
        .dom_req       (dom_req),
        .rd_stb        (bus_rd),
        .wr_stb        (bus_wr),
        .tmo_clear     (tmo_clear),
        .tmo_run       (tmo_run),
        .dir_on        (dir_on),
        .mode          (mode),
        .stby          (standby)
    );

endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_busy,
    input logic cmd_done,
    input logic cmd_err,
    input logic dom_req,
    input logic bus_rd,
    input logic bus_wr,
    input logic standby
);
    // R1: a write is always the second half of a read-modify-write
    a_r1_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd));

    // R1: never a read and a write in the same cycle
    a_r1_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_wr}));

    // R3: error is reported only on the completion pulse
    a_r3_err_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> cmd_done);

    // R7: the domain release is immediately followed by completion
    a_r7_release_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_req) |-> cmd_done);

    // R10: standby changes only two cycles after a read strobe
    a_r10_standby_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(standby) |-> $past(bus_rd, 2));

    // R11: completion lies inside the busy window and lasts one cycle
    a_r11_done_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> cmd_busy);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    // R11: no bus traffic while no command runs
    a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_busy |-> (!bus_rd && !bus_wr));

endmodule

bind modclk_seq clkseq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_busy (cmd_busy),
    .cmd_done (cmd_done),
    .cmd_err  (cmd_err),
    .dom_req  (dom_req),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .standby  (standby)
);

// File: tb/modclk_seq_tb.sv
module modclk_seq_tb;
    localparam int EN_LIM  = 2000;
    localparam int DIS_LIM = 5000;

    localparam int PH_IDLE = 0, PH_DOM = 1, PH_RD = 2, PH_WR = 3,
                   PH_PRD = 4, PH_PCHK = 5, PH_REL = 6, PH_DONE = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        cmd_valid = 1'b0, cmd_enable = 1'b0;
    logic [1:0]  cfg_mode = 2'd2;
    logic        cfg_skip_poll = 1'b0;
    logic        dom_ack = 1'b0, dom_fail = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        us_tick = 1'b0;
    logic        cmd_busy, cmd_done, cmd_err, dom_req, bus_rd, bus_wr, standby;
    logic [31:0] bus_wdata;

    modclk_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_enable(cmd_enable),
        .cmd_busy(cmd_busy), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .cfg_mode(cfg_mode), .cfg_skip_poll(cfg_skip_poll), .dom_req(dom_req),
        .dom_ack(dom_ack), .dom_fail(dom_fail), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .us_tick(us_tick),
        .standby(standby)
    );

    int n_chk = 0, n_bad = 0;
    bit chk_on = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // bench-side control word and domain responder
    logic [31:0] preg = 32'h5AB3_C3C0;
    int          resp_dly = 4;
    logic [1:0]  en_status = 2'd0;
    int          pend = 0;
    logic [1:0]  ptarget = 2'd0;
    int          ack_dly = 2;
    bit          fail_en = 1'b0;
    int          dcnt = 0;
    int          tick_div = 3;
    int          tcnt = 0;
    int          rd_cnt = 0, wr_cnt = 0, cmd_ticks = 0;

    // behavioural reference
    int          m_ph = PH_IDLE;
    bit          m_en = 0, m_skip = 0, m_dom = 0, m_err = 0, m_stby = 0;
    logic [1:0]  m_mode = 2'd0;
    int          m_ticks = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = PH_IDLE; m_en = 0; m_skip = 0; m_dom = 0; m_err = 0;
            m_stby = 0; m_mode = 2'd0; m_ticks = 0;
        end else begin
            case (m_ph)
                PH_IDLE: if (cmd_valid) begin
                    m_en = cmd_enable; m_mode = cfg_mode; m_skip = cfg_skip_poll; m_err = 0;
                    if (cmd_enable) begin m_dom = 1; m_ph = PH_DOM; end
                    else m_ph = (cfg_mode == 2'd0) ? PH_REL : PH_RD;
                end
                PH_DOM: begin
                    if (dom_fail) begin m_err = 1; m_dom = 0; m_ph = PH_DONE; end
                    else if (dom_ack) m_ph = (m_mode == 2'd0) ? PH_DONE : PH_RD;
                end
                PH_RD: m_ph = PH_WR;
                PH_WR: begin
                    m_stby = bus_rdata[18]; m_ticks = 0;
                    m_ph = m_skip ? (m_en ? PH_DONE : PH_REL) : PH_PRD;
                end
                PH_PRD: begin
                    if (us_tick) m_ticks++;
                    m_ph = PH_PCHK;
                end
                PH_PCHK: begin
                    m_stby = bus_rdata[18];
                    if (m_en ? (bus_rdata[17:16] == 2'd0 || bus_rdata[17:16] == 2'd2)
                             : (bus_rdata[17:16] == 2'd3))
                        m_ph = m_en ? PH_DONE : PH_REL;
                    else if (m_ticks >= (m_en ? EN_LIM : DIS_LIM)) begin
                        if (m_en) m_err = 1;
                        m_ph = m_en ? PH_DONE : PH_REL;
                    end else m_ph = PH_PRD;
                    if (us_tick) m_ticks++;
                end
                PH_REL: begin m_dom = 0; m_ph = PH_DONE; end
                default: m_ph = PH_IDLE;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            chk("R11", "busy", 32'(cmd_busy), 32'(m_ph != PH_IDLE));
            chk("R11", "done", 32'(cmd_done), 32'(m_ph == PH_DONE));
            chk("R5",  "err",  32'(cmd_err), 32'(m_err && m_ph == PH_DONE));
            chk("R7",  "dom_req", 32'(dom_req), 32'(m_dom));
            chk("R1",  "bus_rd", 32'(bus_rd), 32'(m_ph == PH_RD || m_ph == PH_PRD));
            chk("R1",  "bus_wr", 32'(bus_wr), 32'(m_ph == PH_WR));
            chk("R10", "standby", 32'(standby), 32'(m_stby));
            if (m_ph == PH_WR)
                chk("R2", "wdata", bus_wdata,
                    m_en ? ((bus_rdata & ~32'h3) | 32'(m_mode)) : (bus_rdata & ~32'h3));
        end
        if (bus_rd) begin
            rd_cnt++;
            bus_rdata = preg;
        end
        if (bus_wr) begin
            wr_cnt++;
            preg = bus_wdata;
            if (resp_dly >= 0) begin
                pend = resp_dly + 1;
                ptarget = (bus_wdata[1:0] != 2'd0) ? en_status : 2'd3;
            end else pend = 0;
        end else if (pend > 0) begin
            pend--;
            if (pend == 0) preg[17:16] = ptarget;
        end
        if (dom_req) begin
            dcnt++;
            dom_ack  = !fail_en && dcnt >= ack_dly;
            dom_fail = fail_en && dcnt >= ack_dly;
        end else begin
            dcnt = 0; dom_ack = 0; dom_fail = 0;
        end
        tcnt++;
        if (tcnt >= tick_div) begin tcnt = 0; us_tick = 1'b1; end
        else us_tick = 1'b0;
        if (cmd_busy && us_tick) cmd_ticks++;
    end

    bit last_err;

    task automatic run_cmd(input bit en, input int hold);
        rd_cnt = 0; wr_cnt = 0; cmd_ticks = 0;
        @(negedge clk); #1;
        cmd_enable = en; cmd_valid = 1'b1;
        repeat (hold) @(negedge clk);
        #1 cmd_valid = 1'b0;
        while (!cmd_done) @(negedge clk);
        last_err = cmd_err;
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "busy", 32'(cmd_busy), 0);
        chk("R12", "done", 32'(cmd_done), 0);
        chk("R12", "err", 32'(cmd_err), 0);
        chk("R12", "dom_req", 32'(dom_req), 0);
        chk("R12", "bus", 32'({bus_rd, bus_wr}), 0);
        chk("R12", "standby", 32'(standby), 0);
        #1 rst_n = 1'b1;
        chk_on = 1'b1;

        // R1/R4: software-supervised enable reaching functional
        cfg_mode = 2'd2; en_status = 2'd0;
        run_cmd(1'b1, 1);
        chk("R1", "mode field", preg & 32'hFFFC_FFFF, 32'h5AB0_C3C2);
        chk("R4", "enable err", 32'(last_err), 0);
        chk("R4", "no timeout", 32'(cmd_ticks < EN_LIM), 1);
        chk("R7", "dom held", 32'(dom_req), 1);

        // R2/R6/R7: disable reaching gated
        run_cmd(1'b0, 1);
        chk("R2", "cleared word", preg, 32'h5AB3_C3C0);
        chk("R6", "disable err", 32'(last_err), 0);
        chk("R7", "dom released", 32'(dom_req), 0);

        // R4: hardware-supervised enable settling at interface idle
        cfg_mode = 2'd1; en_status = 2'd2;
        run_cmd(1'b1, 1);
        chk("R4", "if-idle ready", 32'(last_err), 0);
        chk("R1", "hw code", preg, 32'h5AB2_C3C1);
        run_cmd(1'b0, 1);
        chk("R2", "cleared word", preg, 32'h5AB3_C3C0);

        // R3: domain refusal
        cfg_mode = 2'd2; fail_en = 1'b1;
        run_cmd(1'b1, 1);
        chk("R3", "err", 32'(last_err), 1);
        chk("R3", "no access", 32'(rd_cnt + wr_cnt), 0);
        chk("R3", "word untouched", preg, 32'h5AB3_C3C0);
        chk("R3", "dom dropped", 32'(dom_req), 0);
        fail_en = 1'b0;

        // R5: enable timeout
        tick_div = 1; resp_dly = -1;
        run_cmd(1'b1, 1);
        chk("R5", "err", 32'(last_err), 1);
        chk("R5", "waited", 32'(cmd_ticks >= EN_LIM), 1);

        // R6/R7: disable timeout is not an error and still releases
        preg[17:16] = 2'd0;
        run_cmd(1'b0, 1);
        chk("R6", "err", 32'(last_err), 0);
        chk("R6", "waited", 32'(cmd_ticks >= DIS_LIM), 1);
        chk("R7", "dom dropped", 32'(dom_req), 0);
        tick_div = 3; resp_dly = 4; preg[17:16] = 2'd3;

        // R8: skip polling
        cfg_skip_poll = 1'b1;
        run_cmd(1'b1, 1);
        chk("R8", "enable reads", 32'(rd_cnt), 1);
        chk("R8", "enable writes", 32'(wr_cnt), 1);
        run_cmd(1'b0, 1);
        chk("R8", "disable reads", 32'(rd_cnt), 1);
        chk("R8", "dom dropped", 32'(dom_req), 0);
        cfg_skip_poll = 1'b0;
        repeat (8) @(negedge clk);

        // R9: mode code zero
        cfg_mode = 2'd0;
        run_cmd(1'b1, 1);
        chk("R9", "enable access", 32'(rd_cnt + wr_cnt), 0);
        chk("R9", "dom granted", 32'(dom_req), 1);
        run_cmd(1'b0, 1);
        chk("R9", "disable access", 32'(rd_cnt + wr_cnt), 0);
        chk("R9", "dom released", 32'(dom_req), 0);

        // R10: standby follows bit 18
        cfg_mode = 2'd2; preg[18] = 1'b1;
        run_cmd(1'b1, 1);
        chk("R10", "standby set", 32'(standby), 1);
        preg[18] = 1'b0;
        run_cmd(1'b0, 1);
        chk("R10", "standby clear", 32'(standby), 0);

        // R11: cmd_valid held while busy starts only one command
        run_cmd(1'b1, 3);
        chk("R11", "single write", 32'(wr_cnt), 1);
        chk("R11", "idle after done", 32'(cmd_busy), 0);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule